// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block takes one parallel read request from up to `LANES` lanes and serves it from a scratchpad of 32-bit words that is split into `BANKS` banks. Each lane gives an active flag and a word address. The low address bits select the bank and the remaining bits select the row inside that bank. Each cycle, every bank can supply one word.

In each cycle the block picks one word for each bank and drives one read on that bank's port. It serves every still-pending lane whose address equals a chosen word. When several lanes ask for the same word, all of them are served together in that cycle. When lanes ask for different words in the same bank, they are served over successive cycles. The banks answer with registered data one cycle later. The block then returns each served lane's word together with the mask of lanes served by that read. After the last group has been returned it pulses `done`, and it will then take the next request.

The scratchpad itself sits outside the block. The block owns only the arbitration and the return path.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A lane's bank is its address modulo `BANKS`, taken from the low log2(`BANKS`) address bits. Its row is the address divided by `BANKS`. When a read is issued on a bank, `bank_rd_en` for that bank is high and the bank's slice of `bank_rd_row` carries that row.
- R2: `BANKS` may be 32 or 16, and the same rules apply with either value.
- R3: If every active lane uses a different bank, the request takes a single issue cycle. `done` is high in the cycle that returns that group, and `busy` is low in that cycle.
- R4: In each issue cycle, each bank serves the word of the lowest-numbered still-pending lane that maps to it. Lanes in the same bank that want other words stay pending for later cycles.
- R5: Every pending lane whose address equals a bank's chosen word is served in that same cycle, with no extra cycle.
- R6: The number of cycles with `busy` high equals the largest count of distinct words requested from any one bank. For a request with no active lane, this count is one.
- R7: `rsp_mask` and `rsp_data` appear one cycle after the reads are issued. A served lane's data is the word at its address. A lane that was not served shows zero.
- R8: A lane whose active bit is clear is never served, never causes a bank read, and does not change which word any bank chooses.
- R9: `start` is taken only while `busy` is low. While `busy` is high, `start` and the lane inputs have no effect on the request in progress.
- R10: After reset, `busy`, `done`, `rsp_mask` and `bank_rd_en` are all zero.
- R11: Within one request, every active lane is served exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Takes a new request while `busy` is low |
| lane_active | input | LANES | Active flag of each lane |
| lane_addr | input | LANES*ADDR_W | Word address of each lane; lane n uses bits n*ADDR_W upward |
| busy | output | 1 | A request is being issued |
| bank_rd_en | output | BANKS | Read strobe of each bank |
| bank_rd_row | output | BANKS*ROW_W | Row to read in each bank |
| bank_rd_data | input | BANKS*32 | Registered read data of each bank, one cycle after the strobe |
| rsp_mask | output | LANES | Lanes served by the data on `rsp_data` this cycle |
| rsp_data | output | LANES*32 | Word returned to each lane; zero for lanes not in the mask |
| done | output | 1 | Pulses with the response that completes the request |

## Verification
The bench attacks mapping and arbitration from several directions:
- An address stride equal to the bank count puts every lane in one bank. A design that merged distinct rows would finish too early and return the wrong words.
- All lanes reading one word would take 32 cycles in a design that does not broadcast.
- A mixed pattern combines broadcast lanes with conflicting lanes in the same bank. A wrong winner order shows up at once as a wrong `rsp_mask`.

Inactive lanes are given addresses that would conflict with active lanes. Any leak from them into arbitration stretches the request or adds mask bits. A second `start` is pulsed in the middle of a request, and a design that accepted it would reload its pending set. Both bank counts run the same stimulus, so a bank index taken from the wrong bits fails the row and data comparisons.

// File: rtl/bcs_pkg.sv
// Shared definitions for the bank conflict serializer.
// Assumes every scratchpad entry is one 32-bit word.
package bcs_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bcs_bank_pick.sv
// Chooses the word that one bank supplies in the current cycle: the address
// of the lowest-numbered pending lane that maps to this bank.
// Assumes the bank index is taken from the low BANK_W address bits.
module bcs_bank_pick #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 12,
    parameter int BANK_W  = 5,
    parameter int BANK_ID = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    output logic                    found,
    output logic [ADDR_W-1:0]       win_addr
);

    // Scan from the top lane down so that the lowest pending lane wins.
    always_comb begin
        found    = 1'b0;
        win_addr = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pend[l] && (addr_flat[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID))) begin
                found    = 1'b1;
                win_addr = addr_flat[l*ADDR_W +: ADDR_W];
            end
        end
    end

    // R1: a word chosen for this bank must belong to this bank.
    a_r1_bank_map: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (win_addr[BANK_W-1:0] == BANK_W'(BANK_ID)));

    // R4: a bank can choose a word only while some lane is still pending.
    a_r4_pick_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (pend != '0));

endmodule

// File: rtl/bcs_lane_grant.sv
// Marks as served every pending lane whose address equals the word chosen
// for its bank. Lanes that read the same word are served together.
// Assumes one chosen word per bank, from bcs_bank_pick.
module bcs_lane_grant #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    parameter int BANK_W = 5
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [BANKS-1:0]        found,
    input  logic [BANKS*ADDR_W-1:0] win_flat,
    output logic [LANES-1:0]        grant
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BANK_W-1:0] bk;
        // Bank index of this lane.
        assign bk = addr_flat[l*ADDR_W +: BANK_W];
        // Served when pending and the lane's word is the one chosen for its bank.
        assign grant[l] = pend[l] && found[bk]
                          && (addr_flat[l*ADDR_W +: ADDR_W] == win_flat[bk*ADDR_W +: ADDR_W]);
    end

endmodule

// File: rtl/bcs_resp_mux.sv
// Routes each bank's returned word to the lanes served from that bank.
// Lanes that were not served get zero.
// Assumes bank data lines up with the registered served mask.
module bcs_resp_mux #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int BANK_W = 5
) (
    input  logic [LANES-1:0]                  served,
    input  logic [LANES*BANK_W-1:0]           bank_idx_flat,
    input  logic [BANKS*bcs_pkg::WORD_W-1:0]  bank_rd_data,
    output logic [LANES*bcs_pkg::WORD_W-1:0]  rsp_data
);
    import bcs_pkg::*;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BANK_W-1:0] bk;
        // Bank this lane was served from.
        assign bk = bank_idx_flat[l*BANK_W +: BANK_W];
        // Select that bank's word, or zero when the lane was not served.
        assign rsp_data[l*WORD_W +: WORD_W] =
            served[l] ? bank_rd_data[bk*WORD_W +: WORD_W] : word_t'(0);
    end

endmodule

// File: rtl/bank_conflict_serializer.sv
// Serves one parallel read request against a banked scratchpad. Each cycle
// it issues one word per bank and retires every lane that wants that word.
// It repeats until no lane is pending, then pulses done with the last response.
// Assumes BANKS is 16 or 32, and that the banks return registered data one
// cycle after the strobe.
module bank_conflict_serializer #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 12,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [LANES-1:0]                    lane_active,
    input  logic [LANES*ADDR_W-1:0]             lane_addr,
    output logic                                busy,
    output logic [BANKS-1:0]                    bank_rd_en,
    output logic [BANKS*ROW_W-1:0]              bank_rd_row,
    input  logic [BANKS*bcs_pkg::WORD_W-1:0]    bank_rd_data,
    output logic [LANES-1:0]                    rsp_mask,
    output logic [LANES*bcs_pkg::WORD_W-1:0]    rsp_data,
    output logic                                done
);

    logic                    busy_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES-1:0]        served_q;
    logic                    last_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        grant;
    logic [LANES-1:0]        pend_next;
    logic [BANKS-1:0]        found;
    logic [BANKS*ADDR_W-1:0] win_flat;
    logic [LANES*BANK_W-1:0] bank_idx_flat;

    // R2: only the two supported bank counts are legal.
    initial begin
        a_r2_bank_count: assert (BANKS == 16 || BANKS == 32);
    end

    // One word chooser per bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bcs_bank_pick #(
            .LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_ID(b)
        ) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend     (pend_q),
            .addr_flat(addr_q),
            .found    (found[b]),
            .win_addr (win_flat[b*ADDR_W +: ADDR_W])
        );
        // Strobe the bank only while issuing and when it has a word to read.
        assign bank_rd_en[b] = busy_q & found[b];
        assign bank_rd_row[b*ROW_W +: ROW_W] = win_flat[b*ADDR_W + BANK_W +: ROW_W];
    end

    bcs_lane_grant #(
        .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) u_grant (
        .pend     (pend_q),
        .addr_flat(addr_q),
        .found    (found),
        .win_flat (win_flat),
        .grant    (grant)
    );

    // Bank index of each held lane address, used by the return path.
    for (genvar l = 0; l < LANES; l++) begin : g_idx
        assign bank_idx_flat[l*BANK_W +: BANK_W] = addr_q[l*ADDR_W +: BANK_W];
    end

    assign pend_next = pend_q & ~grant;

    // Request control: take a request when idle, then retire groups every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            pend_q   <= '0;
            served_q <= '0;
            last_q   <= 1'b0;
        end else if (busy_q) begin
            pend_q   <= pend_next;
            served_q <= grant;
            last_q   <= (pend_next == '0);
            busy_q   <= (pend_next != '0);
        end else begin
            served_q <= '0;
            last_q   <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                pend_q <= lane_active;
            end
        end
    end

    // Hold the lane addresses for the whole request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!busy_q && start) begin
            addr_q <= lane_addr;
        end
    end

    bcs_resp_mux #(
        .LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W)
    ) u_resp (
        .served       (served_q),
        .bank_idx_flat(bank_idx_flat),
        .bank_rd_data (bank_rd_data),
        .rsp_data     (rsp_data)
    );

    assign busy     = busy_q;
    assign rsp_mask = served_q;
    assign done     = last_q;

    // R8: a lane is reported served only if it was pending in the issue cycle.
    a_r8_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ((served_q & ~$past(pend_q)) == '0));

    // R6: every issue cycle with pending lanes retires at least one lane.
    a_r6_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && pend_q != '0) |=> (served_q != '0));

    // R3: done comes with the last response, once issuing has stopped.
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy_q);

    // R1: banks are read only during a request.
    a_r1_reads_in_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd_en != '0) |-> busy_q);

    // R9: the held addresses do not move while a request is in progress.
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(addr_q));

    // R11: a lane served in a cycle is no longer pending afterwards.
    a_r11_once: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ((served_q & pend_q) == '0));

endmodule

// File: tb/bank_conflict_serializer_test.sv
// Bench: two instances (32 and 16 banks) with behavioural scratchpads and a
// cycle-by-cycle reference model of the arbitration.
module bank_conflict_serializer_test;

    localparam int LANES  = 32;
    localparam int ADDR_W = 12;
    localparam int NB0    = 32;
    localparam int NB1    = 16;
    localparam int RW0    = ADDR_W - 5;
    localparam int RW1    = ADDR_W - 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LANES-1:0]        lane_active = '0;
    logic [LANES*ADDR_W-1:0] lane_addr = '0;

    logic                  busy0, busy1, done0, done1;
    logic [NB0-1:0]        en0;
    logic [NB1-1:0]        en1;
    logic [NB0*RW0-1:0]    row0;
    logic [NB1*RW1-1:0]    row1;
    logic [NB0*32-1:0]     rd0 = '0;
    logic [NB1*32-1:0]     rd1 = '0;
    logic [LANES-1:0]      mask0, mask1;
    logic [LANES*32-1:0]   data0, data1;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int cur_addr [LANES];

    always #2 clk = ~clk;

    bank_conflict_serializer #(.LANES(LANES), .BANKS(NB0), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_active(lane_active),
        .lane_addr(lane_addr), .busy(busy0), .bank_rd_en(en0), .bank_rd_row(row0),
        .bank_rd_data(rd0), .rsp_mask(mask0), .rsp_data(data0), .done(done0));

    bank_conflict_serializer #(.LANES(LANES), .BANKS(NB1), .ADDR_W(ADDR_W)) uut16 (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_active(lane_active),
        .lane_addr(lane_addr), .busy(busy1), .bank_rd_en(en1), .bank_rd_row(row1),
        .bank_rd_data(rd1), .rsp_mask(mask1), .rsp_data(data1), .done(done1));

    function automatic logic [31:0] word_of(int a);
        return a * 32'h9E3779B1 + 32'h01234567;
    endfunction

    // Behavioural scratchpads with one cycle of read latency.
    always @(posedge clk) begin
        for (int b = 0; b < NB0; b++)
            rd0[b*32 +: 32] <= en0[b] ? word_of(int'(row0[b*RW0 +: RW0]) * NB0 + b) : 32'h0;
        for (int b = 0; b < NB1; b++)
            rd1[b*32 +: 32] <= en1[b] ? word_of(int'(row1[b*RW1 +: RW1]) * NB1 + b) : 32'h0;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [LANES-1:0] model_grant(logic [LANES-1:0] pend, int nb);
        logic [LANES-1:0] g = '0;
        int claim [32];
        bit taken [32];
        for (int b = 0; b < 32; b++) begin taken[b] = 0; claim[b] = 0; end
        for (int l = 0; l < LANES; l++) begin
            if (pend[l]) begin
                int b = cur_addr[l] % nb;
                if (!taken[b]) begin taken[b] = 1; claim[b] = cur_addr[l]; end
                if (claim[b] == cur_addr[l]) g[l] = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic int expected_cycles(logic [LANES-1:0] act, int nb);
        int best = 1;
        for (int b = 0; b < nb; b++) begin
            int cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                bit seen = 0;
                if (act[l] && cur_addr[l] % nb == b) begin
                    for (int k = 0; k < l; k++)
                        if (act[k] && cur_addr[k] == cur_addr[l]) seen = 1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > best) best = cnt;
        end
        return best;
    endfunction

    task automatic drive_addrs();
        for (int l = 0; l < LANES; l++) lane_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(cur_addr[l]);
    endtask

    // Runs one request on both instances, comparing every cycle to the model.
    task automatic run_req(input logic [LANES-1:0] act, input string scen, input int pulse_at);
        logic [LANES-1:0] pend [2];
        logic [LANES-1:0] prevg [2];
        logic [LANES-1:0] seen [2];
        bit mbusy [2];
        bit plast [2];
        bit fin [2];
        int issues [2];
        int cyc = 0;
        @(negedge clk);
        start = 1'b1; lane_active = act; drive_addrs();
        @(negedge clk);
        start = 1'b0;
        for (int d = 0; d < 2; d++) begin
            pend[d] = act; prevg[d] = '0; seen[d] = '0; mbusy[d] = 1; plast[d] = 0;
            fin[d] = 0; issues[d] = 0;
        end
        while (!(fin[0] && fin[1])) begin
            if (cyc == pulse_at && mbusy[0] && mbusy[1]) begin
                start = 1'b1; lane_active = ~act; lane_addr = ~lane_addr;
            end else begin
                start = 1'b0; lane_active = act; drive_addrs();
            end
            for (int d = 0; d < 2; d++) begin
                if (!fin[d]) begin
                    int nb = (d == 0) ? NB0 : NB1;
                    string tg = {scen, (d == 0) ? " R4" : " R2"};
                    logic b_busy = (d == 0) ? busy0 : busy1;
                    logic b_done = (d == 0) ? done0 : done1;
                    logic [LANES-1:0] b_mask = (d == 0) ? mask0 : mask1;
                    check(b_busy == mbusy[d], {scen, " R9 busy"}, 64'(b_busy), 64'(mbusy[d]));
                    check(b_mask == prevg[d], tg, 64'(b_mask), 64'(prevg[d]));
                    check(b_done == plast[d], {scen, " R3 done"}, 64'(b_done), 64'(plast[d]));
                    for (int l = 0; l < LANES; l++) begin
                        logic [31:0] got = (d == 0) ? data0[l*32 +: 32] : data1[l*32 +: 32];
                        logic [31:0] exp = prevg[d][l] ? word_of(cur_addr[l]) : 32'h0;
                        if (got != exp) check(0, {scen, " R7 data"}, 64'(got), 64'(exp));
                    end
                    checks++;
                    seen[d] |= prevg[d];
                    if (mbusy[d]) begin
                        logic [LANES-1:0] g = model_grant(pend[d], nb);
                        for (int b = 0; b < nb; b++) begin
                            bit ee = 0;
                            int er = 0;
                            logic ge = (d == 0) ? en0[b] : en1[b];
                            int gr = (d == 0) ? int'(row0[b*RW0 +: RW0]) : int'(row1[b*RW1 +: RW1]);
                            for (int l = 0; l < LANES; l++)
                                if (g[l] && cur_addr[l] % nb == b) begin ee = 1; er = cur_addr[l] / nb; end
                            if (ge != ee) check(0, {scen, " R1 en"}, 64'(ge), 64'(ee));
                            if (ee && gr != er) check(0, {scen, " R1 row"}, 64'(gr), 64'(er));
                        end
                        checks++;
                        pend[d] &= ~g;
                        issues[d]++;
                        plast[d] = (pend[d] == '0);
                        mbusy[d] = (pend[d] != '0);
                        prevg[d] = g;
                    end else begin
                        fin[d] = 1;
                        check(issues[d] == expected_cycles(act, nb), {scen, " R6 cycles"},
                              64'(issues[d]), 64'(expected_cycles(act, nb)));
                        check(seen[d] == act, {scen, " R11 served"}, 64'(seen[d]), 64'(act));
                    end
                end
            end
            cyc++;
            if (cyc > 200) begin
                check(0, {scen, " R6 hang"}, 64'(cyc), 64'(0));
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        repeat (3) @(negedge clk);
        // R10: reset state.
        check(busy0 == 0 && busy1 == 0, "R10 busy", 64'({busy0, busy1}), 0);
        check(done0 == 0 && done1 == 0, "R10 done", 64'({done0, done1}), 0);
        check(mask0 == 0 && mask1 == 0, "R10 mask", 64'({mask0, mask1}), 0);
        check(en0 == 0 && en1 == 0, "R10 en", 64'({en0, en1}), 0);
        rst_n = 1'b1;

        for (int l = 0; l < LANES; l++) cur_addr[l] = 200 + l;
        run_req('1, "R3 distinct", -1);
        for (int l = 0; l < LANES; l++) cur_addr[l] = 2 * l + 7;
        run_req('1, "R4 stride2", -1);
        for (int l = 0; l < LANES; l++) cur_addr[l] = 777;
        run_req('1, "R5 broadcast", -1);
        for (int l = 0; l < LANES; l++) cur_addr[l] = 32 * l + 3;
        run_req('1, "R4 onebank", -1);
        for (int l = 0; l < LANES; l++)
            cur_addr[l] = (l < 8) ? 100 : (l < 16) ? 100 + 32 * (l - 7) : 1000 + l;
        run_req('1, "R5 mixed", -1);
        // Inactive lanes aim at the bank of active ones with other rows.
        for (int l = 0; l < LANES; l++) cur_addr[l] = (l % 2 == 0) ? 500 + l : 500 + (l - 1) + 64 * l;
        run_req(32'h5555_5555, "R8 inactive", -1);
        run_req('0, "R8 empty", -1);
        for (int l = 0; l < LANES; l++) cur_addr[l] = 64 * l + 9;
        run_req('1, "R9 midstart", 3);
        for (int n = 0; n < 40; n++) begin
            logic [LANES-1:0] act;
            for (int l = 0; l < LANES; l++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                cur_addr[l] = (n % 2 == 0) ? int'(lfsr[11:0]) : int'(lfsr[5:0]) * 16 + int'(lfsr[7:6]);
            end
            act = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            run_req(act, "R2 random", (n % 5 == 0) ? 1 : -1);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule